// File: doc/BRIEF.md
# Discharge Overcurrent Fault Timer

This block sits behind the discharge overcurrent or short-circuit comparator of a battery pack controller. It counts how long the comparator has stayed high against a programmable delay, and once that delay has passed it latches a fault that turns off the discharge path. The fault then waits out a fixed hold-off before it may clear. Depending on a mode bit, it clears either when a charger is attached or when the overcurrent condition has gone away.

An 8-bit configuration register sets the behaviour. Bits 4:0 hold a delay code, bit 5 selects the recovery mode, and bits 6 and 7 are enables that pass straight to outputs for the precharge logic and the cell-balancing logic. All timing is counted in pulses of a one-millisecond tick input. The system clock only samples the inputs and moves the state.

Top module: `dchg_ocp_timer`

## Requirements
- R1: After reset every configuration bit is 0, `fault` is 0, `dsg_en` is 1 and both pass-through enables are 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` at the next clock edge. Bit 7 then drives `bal_en` and bit 6 drives `prechg_en`.
- R3: For delay codes 0x00 to 0x0F (bit 4 clear), the fault latches on the clock edge of the (code+1)×20-th consecutive tick at which the comparator is sampled high, and not one tick earlier.
- R4: For delay codes 0x10 to 0x1F (bit 4 set), the fault latches on the (code−15)×100-th consecutive high tick, and not one tick earlier.
- R5: Any clock cycle in which the comparator is low restarts the qualification count, so a glitch shorter than the delay never latches a fault.
- R6: Only cycles with `ms_tick` high advance the qualification count. Cycles without a tick neither count nor restart it.
- R7: `dsg_en` is the inverse of `fault` at all times.
- R8: With bit 5 at 0, a latched fault clears only on a clock edge after 12800 ticks have been counted since it latched, and only when `chg_present` is high at that edge. A charger attached earlier, or a comparator that is low, does not clear it.
- R9: With bit 5 at 1, a latched fault clears only after the same 12800-tick hold-off, and only on an edge at which the comparator is low. A release before the hold-off ends, or a charger, does not clear it.
- R10: A register write while a fault is latched leaves the fault unchanged. A write also restarts the qualification count, and the new delay code applies to the next qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| oc_cmp | input | 1 | Overcurrent / short-circuit comparator level, high means overcurrent |
| chg_present | input | 1 | High while a charger is attached |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| fault | output | 1 | Latched discharge overcurrent fault |
| dsg_en | output | 1 | Discharge path enable, low while the fault is latched |
| prechg_en | output | 1 | Precharge enable, from configuration bit 6 |
| bal_en | output | 1 | Cell-balancing enable, from configuration bit 7 |

## Verification
The assertions check four things on every cycle. The fault can only rise on a qualification hit. It can only fall once the hold-off count is complete. When it falls, the cause matches the selected recovery mode. The qualification count stays below the programmed delay and returns to zero after a low comparator cycle. What only the scenarios can show is the exact latch cycle for every one of the 32 delay codes, the exact clear cycle at the end of the hold-off, the rejection of a glitch, counting only on tick cycles, and that early charger or release events and mid-fault writes leave the fault in place.

// File: rtl/ocf_pkg.sv
package ocf_pkg;
  localparam int CODE_W = 5;
  localparam int CFG_W  = 8;

  typedef struct packed {
    logic              bal_en;
    logic              prechg_en;
    logic              auto_rec;
    logic [CODE_W-1:0] code;
  } ocf_cfg_t;
endpackage

// File: rtl/ocf_rst_sync.sv
module ocf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ocf_cfg_reg.sv
module ocf_cfg_reg
  import ocf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output ocf_cfg_t         cfg
);
  ocf_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = ocf_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  a_r2_cfg_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));
  a_r2_cfg_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == ocf_cfg_t'($past(wdata))));
endmodule

// File: rtl/ocf_delay_map.sv
module ocf_delay_map
  import ocf_pkg::*;
#(
  parameter int FINE_MS   = 20,
  parameter int COARSE_MS = 100,
  parameter int DLY_W     = 11
) (
  input  logic [CODE_W-1:0] code,
  output logic [DLY_W-1:0]  dly_ticks
);
  localparam int STEP_IDX_W = CODE_W - 1;

  logic [DLY_W-1:0] steps;

  always_comb begin
    steps = DLY_W'(code[STEP_IDX_W-1:0]) + DLY_W'(1);
    if (code[CODE_W-1]) dly_ticks = DLY_W'(steps * DLY_W'(COARSE_MS));
    else                dly_ticks = DLY_W'(steps * DLY_W'(FINE_MS));
  end
endmodule

// File: rtl/ocf_qualifier.sv
module ocf_qualifier #(
  parameter int DLY_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmp,
  input  logic             armed,
  input  logic             reload,
  input  logic [DLY_W-1:0] dly_ticks,
  output logic             hit
);
  logic [DLY_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + DLY_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (!armed || reload || !cmp) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_inc >= dly_ticks) begin
        hit   = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r5_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp |=> (cnt_q == '0));
  a_r3_count_below_delay: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < dly_ticks);
  a_r6_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && cmp && armed && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/ocf_recovery.sv
module ocf_recovery #(
  parameter int HOLD_TICKS = 12800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic auto_rec,
  input  logic cmp,
  input  logic chg,
  output logic fault
);
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
  localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(HOLD_TICKS);

  logic              fault_q, fault_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              hold_done, release_ok;

  assign hold_done  = (hold_q == HOLD_END);
  assign release_ok = auto_rec ? !cmp : chg;

  always_comb begin
    fault_d = fault_q;
    hold_d  = hold_q;
    if (!fault_q) begin
      hold_d = '0;
      if (hit) fault_d = 1'b1;
    end else begin
      if (!hold_done && tick) hold_d = hold_q + HOLD_W'(1);
      if (hold_done && release_ok) fault_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      fault_q <= fault_d;
      hold_q  <= hold_d;
    end
  end

  assign fault = fault_q;

  a_r3_set_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(hit));
  a_r8_clear_after_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> ($past(hold_q) == HOLD_END));
  a_r9_clear_cause_matches_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> ($past(auto_rec) ? !$past(cmp) : $past(chg)));
  a_r8_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= HOLD_END);
endmodule

// File: rtl/dchg_ocp_timer.sv
module dchg_ocp_timer
  import ocf_pkg::*;
#(
  parameter int FINE_MS    = 20,
  parameter int COARSE_MS  = 100,
  parameter int HOLD_TICKS = 12800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       oc_cmp,
  input  logic       chg_present,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic       fault,
  output logic       dsg_en,
  output logic       prechg_en,
  output logic       bal_en
);
  localparam int STEPS   = 1 << (CODE_W - 1);
  localparam int MAX_DLY = (STEPS * COARSE_MS > STEPS * FINE_MS) ? STEPS * COARSE_MS : STEPS * FINE_MS;
  localparam int DLY_W   = $clog2(MAX_DLY + 1);

  logic             rst_sync_n;
  ocf_cfg_t         cfg;
  logic [DLY_W-1:0] dly_ticks;
  logic             hit;
  logic             fault_int;

  ocf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ocf_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  ocf_delay_map #(.FINE_MS(FINE_MS), .COARSE_MS(COARSE_MS), .DLY_W(DLY_W)) u_map (
    .code      (cfg.code),
    .dly_ticks (dly_ticks)
  );

  ocf_qualifier #(.DLY_W(DLY_W)) u_qual (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (ms_tick),
    .cmp       (oc_cmp),
    .armed     (!fault_int),
    .reload    (cfg_we),
    .dly_ticks (dly_ticks),
    .hit       (hit)
  );

  ocf_recovery #(.HOLD_TICKS(HOLD_TICKS)) u_rec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (ms_tick),
    .hit      (hit),
    .auto_rec (cfg.auto_rec),
    .cmp      (oc_cmp),
    .chg      (chg_present),
    .fault    (fault_int)
  );

  assign fault     = fault_int;
  assign dsg_en    = ~fault_int;
  assign prechg_en = cfg.prechg_en;
  assign bal_en    = cfg.bal_en;

  a_r10_write_keeps_fault: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && fault_int && !(u_rec.hold_done)) |=> fault_int);
endmodule

// File: tb/dchg_ocp_timer_tb_top.sv
`timescale 1ns/1ps
module dchg_ocp_timer_tb_top;
  localparam int HOLD = 12800;

  logic       clk;
  logic       rst_n;
  logic       ms_tick;
  logic       oc_cmp;
  logic       chg_present;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       fault;
  logic       dsg_en;
  logic       prechg_en;
  logic       bal_en;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dchg_ocp_timer dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ms_tick     (ms_tick),
    .oc_cmp      (oc_cmp),
    .chg_present (chg_present),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .fault       (fault),
    .dsg_en      (dsg_en),
    .prechg_en   (prechg_en),
    .bal_en      (bal_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_fault(input int exp, input string req);
    chk(fault == exp[0], req, int'(fault), exp);
    chk(dsg_en == !exp[0], "R7 dsg_en", int'(dsg_en), int'(!exp[0]));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; oc_cmp = 1'b0; chg_present = 1'b0; cfg_we = 1'b0;
    cfg_wdata = '0; ms_tick = 1'b1;
    step(2);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic qualify(input int n, input string req);
    oc_cmp = 1'b1;
    step(n - 1);
    chk_fault(0, req);
    step(1);
    chk_fault(1, req);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk_fault(0, "R1 fault");
    chk(prechg_en == 1'b0, "R1 prechg_en", int'(prechg_en), 0);
    chk(bal_en == 1'b0, "R1 bal_en", int'(bal_en), 0);

    // R3 / R4 sweep of all delay codes
    for (int code = 0; code < 32; code++) begin
      int n;
      n = (code < 16) ? (code + 1) * 20 : (code - 15) * 100;
      do_reset();
      wr(8'(code));
      qualify(n, (code < 16) ? "R3 delay" : "R4 delay");
    end

    // R5 glitch shorter than the delay (code 0x02 = 60 ticks)
    do_reset();
    wr(8'h02);
    oc_cmp = 1'b1; step(59);
    oc_cmp = 1'b0; step(1);
    chk_fault(0, "R5 glitch");
    qualify(60, "R5 restart");

    // R6 only tick cycles count (code 0x00 = 20 ticks)
    do_reset();
    wr(8'h00);
    ms_tick = 1'b0; oc_cmp = 1'b1;
    for (int i = 0; i < 19; i++) begin
      ms_tick = 1'b1; step(1);
      ms_tick = 1'b0; step(2);
    end
    chk_fault(0, "R6 19 ticks");
    ms_tick = 1'b1; step(1);
    chk_fault(1, "R6 20 ticks");

    // R8 charger mode: early charger and released comparator ignored
    do_reset();
    wr(8'h00);
    qualify(20, "R8 latch");
    oc_cmp = 1'b0;
    step(5000);
    chg_present = 1'b1; step(10); chg_present = 1'b0;
    step(HOLD - 5010);
    chk_fault(1, "R8 early charger");
    step(100);
    chk_fault(1, "R8 no charger");
    chg_present = 1'b1; step(1);
    chk_fault(0, "R8 charger clears");
    chg_present = 1'b0;

    // R8 exact hold-off boundary with charger held
    do_reset();
    wr(8'h00);
    qualify(20, "R8 latch2");
    chg_present = 1'b1;
    step(HOLD);
    chk_fault(1, "R8 at hold-off");
    step(1);
    chk_fault(0, "R8 after hold-off");
    chg_present = 1'b0;

    // R9 self recovery, with early release, charger and mid-fault write (R10, R2)
    do_reset();
    wr(8'h20);
    qualify(20, "R9 latch");
    chg_present = 1'b1;
    step(3000);
    oc_cmp = 1'b0; step(5); oc_cmp = 1'b1;
    step(1000);
    chk_fault(1, "R9 early release");
    wr(8'hE1);
    chk_fault(1, "R10 write in fault");
    chk(prechg_en == 1'b1, "R2 prechg_en", int'(prechg_en), 1);
    chk(bal_en == 1'b1, "R2 bal_en", int'(bal_en), 1);
    step(HOLD - 4006);
    chk_fault(1, "R9 hold-off end");
    step(50);
    chk_fault(1, "R9 charger ignored");
    chg_present = 1'b0;
    oc_cmp = 1'b0; step(1);
    chk_fault(0, "R9 release clears");
    step(2);
    qualify(40, "R10 new code");

    // R9 exact boundary, comparator released at once
    do_reset();
    wr(8'h3F);
    qualify(1600, "R9 latch2");
    oc_cmp = 1'b0;
    step(HOLD);
    chk_fault(1, "R9 at hold-off");
    step(1);
    chk_fault(0, "R9 after hold-off");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule